// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two IEEE-754 binary floating-point operands. Both operands are single precision or both are double precision, and a format input chooses which. A four-bit predicate code selects any combination of the relations less-than, equal and unordered. The block ORs together the selected relations that hold and registers that single bit as the condition flag. Conditional branches that test for true or for false read this flag.

NaN operands follow fixed rules. When either operand is a NaN, only the unordered relation holds. An ordered test therefore gives false, and a test that includes the unordered relation gives true. An invalid-operation pulse is raised on two conditions: when a signalling NaN takes part in any compare, and when a signalling predicate meets any NaN.

The host presents the operands, the format and the predicate with `cmp_valid` high for one cycle. The flag takes the new result on that clock edge and keeps it until the next valid compare.

Top module: `fpcmp_unit`

## Requirements
- R1: After reset, `cond_flag` and `invalid_flag` are both 0.
- R2: With `fmt_dbl`=0, each operand is the single-precision value in bits [31:0] of its port. Bits [63:32] have no effect on the result.
- R3: The predicate bits are: bit 0 selects unordered, bit 1 selects equal, bit 2 selects less-than (a < b). On a valid compare the flag becomes the OR of the selected relations that hold. A code with bits [2:0] = 0 gives 0.
- R4: If either operand is a NaN (maximum exponent, nonzero fraction), less-than and equal are both false. A predicate with bit 0 clear then gives 0.
- R5: If either operand is a NaN, the unordered relation holds. A predicate with bit 0 set then gives 1.
- R6: Positive zero and negative zero compare equal and not less.
- R7: Non-NaN operands are ordered by sign and magnitude. Negative values are below positive values, a larger magnitude is lower among negatives, and the infinities are the extremes.
- R8: A signalling NaN operand (fraction MSB 0, fraction nonzero) raises `invalid_flag` for one cycle after the compare, whatever the predicate.
- R9: With predicate bit 3 (signalling) set, a quiet NaN operand raises `invalid_flag`. With bit 3 clear, a quiet NaN does not raise it.
- R10: Without `cmp_valid`, `cond_flag` holds its value and `invalid_flag` is 0 on the next cycle.
- R11: With `fmt_dbl`=1, the full 64-bit double-precision operands are compared under the same rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Start a compare in this cycle |
| fmt_dbl | input | 1 | 1 = double precision, 0 = single precision in the low bits |
| pred | input | 4 | Predicate code: [0] unordered, [1] equal, [2] less, [3] signalling |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cond_flag | output | 1 | Registered compare result |
| invalid_flag | output | 1 | One-cycle invalid-operation pulse |

## Verification
Ordinary finite pairs are run with several predicates. These show whether each relation bit is decoded on its own and whether the results are ORed correctly. Pairs of negatives, of mixed signs, of infinities and of opposite-signed zeros show whether the ordering is sign-magnitude and not plain two's complement. Quiet and signalling NaNs are each paired with ordered, unordered and signalling predicates. This separates the condition-result rules from the two separate causes of an invalid pulse. In single format the upper operand bits are filled with NaN-like values, which shows that only the low word is read. Idle cycles with changing inputs show that the flag holds and that the invalid pulse lasts one cycle.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
   // predicate code bit positions
   localparam int PB_UN  = 0;
   localparam int PB_EQ  = 1;
   localparam int PB_LT  = 2;
   localparam int PB_SIG = 3;
   localparam int PRED_W = 4;

   typedef struct packed {
      logic lt;
      logic eq;
      logic un;
   } rel_t;

   typedef struct packed {
      rel_t rel;
      logic nan_any;
      logic snan_any;
   } lane_res_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int MAG_W = EXP_W + FRAC_W,
   localparam int VAL_W = MAG_W + 1
) (
   input  logic [VAL_W-1:0] val,
   output logic             is_nan,
   output logic             is_snan,
   output logic             is_zero,
   output logic             sign,
   output logic [MAG_W-1:0] mag
);
   logic [EXP_W-1:0]  expo;
   logic [FRAC_W-1:0] frac;
   logic              exp_max;
   logic              frac_nz;

   always_comb begin
      sign    = val[VAL_W-1];
      mag     = val[MAG_W-1:0];
      expo    = val[MAG_W-1:FRAC_W];
      frac    = val[FRAC_W-1:0];
      exp_max = &expo;
      frac_nz = |frac;
      is_nan  = exp_max && frac_nz;
      is_snan = is_nan && !frac[FRAC_W-1];
      is_zero = !(|mag);
   end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
   import fpcmp_pkg::*;
#(
   parameter int MAG_W = 31
) (
   input  logic             sign_a,
   input  logic             sign_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   input  logic             nan_a,
   input  logic             nan_b,
   input  logic             zero_a,
   input  logic             zero_b,
   output rel_t             rel
);
   logic mag_lt;
   logic mag_eq;

   always_comb begin
      mag_lt = mag_a < mag_b;
      mag_eq = mag_a == mag_b;
      rel    = '0;
      if (nan_a || nan_b) begin
         rel.un = 1'b1;
      end else if (zero_a && zero_b) begin
         rel.eq = 1'b1;
      end else if (sign_a != sign_b) begin
         rel.lt = sign_a;
      end else if (!sign_a) begin
         rel.lt = mag_lt;
         rel.eq = mag_eq;
      end else begin
         rel.lt = !mag_lt && !mag_eq;
         rel.eq = mag_eq;
      end
   end
endmodule

// File: rtl/fpcmp_lane.sv
module fpcmp_lane
   import fpcmp_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int MAG_W = EXP_W + FRAC_W,
   localparam int VAL_W = MAG_W + 1
) (
   input  logic [VAL_W-1:0] a,
   input  logic [VAL_W-1:0] b,
   output lane_res_t        res
);
   logic             nan_a, nan_b, snan_a, snan_b, zero_a, zero_b, sgn_a, sgn_b;
   logic [MAG_W-1:0] mag_a, mag_b;
   rel_t             rel;

   fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
      .val(a), .is_nan(nan_a), .is_snan(snan_a), .is_zero(zero_a),
      .sign(sgn_a), .mag(mag_a)
   );

   fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
      .val(b), .is_nan(nan_b), .is_snan(snan_b), .is_zero(zero_b),
      .sign(sgn_b), .mag(mag_b)
   );

   fpcmp_order #(.MAG_W(MAG_W)) u_ord (
      .sign_a(sgn_a), .sign_b(sgn_b), .mag_a(mag_a), .mag_b(mag_b),
      .nan_a(nan_a), .nan_b(nan_b), .zero_a(zero_a), .zero_b(zero_b),
      .rel(rel)
   );

   always_comb begin
      res.rel      = rel;
      res.nan_any  = nan_a || nan_b;
      res.snan_any = snan_a || snan_b;
   end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
   import fpcmp_pkg::*;
#(
   parameter int  SGL_EXP_W  = 8,
   parameter int  SGL_FRAC_W = 23,
   parameter int  DBL_EXP_W  = 11,
   parameter int  DBL_FRAC_W = 52,
   parameter bit  HAS_SINGLE = 1'b1,
   localparam int SGL_W      = 1 + SGL_EXP_W + SGL_FRAC_W,
   localparam int DBL_W      = 1 + DBL_EXP_W + DBL_FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_valid,
   input  logic             fmt_dbl,
   input  logic [PRED_W-1:0] pred,
   input  logic [DBL_W-1:0] op_a,
   input  logic [DBL_W-1:0] op_b,
   output logic             cond_flag,
   output logic             invalid_flag
);
   initial begin
      if (SGL_W > DBL_W)
         $error("single format wider than double format");
      if (SGL_FRAC_W < 2 || DBL_FRAC_W < 2)
         $error("fraction needs a quiet bit and a payload bit");
   end

   lane_res_t dbl_res;
   lane_res_t sgl_res;
   lane_res_t sel_res;
   logic      result_c;
   logic      invalid_c;

   fpcmp_lane #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W)) u_dbl (
      .a(op_a), .b(op_b), .res(dbl_res)
   );

   generate
      if (HAS_SINGLE) begin : g_sgl
         fpcmp_lane #(.EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W)) u_sgl (
            .a(op_a[SGL_W-1:0]), .b(op_b[SGL_W-1:0]), .res(sgl_res)
         );
      end else begin : g_no_sgl
         assign sgl_res = dbl_res;
      end
   endgenerate

   always_comb begin
      sel_res  = fmt_dbl ? dbl_res : sgl_res;
      result_c = (pred[PB_UN] && sel_res.rel.un) ||
                 (pred[PB_EQ] && sel_res.rel.eq) ||
                 (pred[PB_LT] && sel_res.rel.lt);
      invalid_c = sel_res.snan_any || (pred[PB_SIG] && sel_res.nan_any);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cond_flag    <= 1'b0;
         invalid_flag <= 1'b0;
      end else begin
         invalid_flag <= cmp_valid && invalid_c;
         if (cmp_valid)
            cond_flag <= result_c;
      end
   end
endmodule

// File: rtl/fpcmp_chk.sv
module fpcmp_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmp_valid,
   input logic        fmt_dbl,
   input logic [3:0]  pred,
   input logic [63:0] op_a,
   input logic [63:0] op_b,
   input logic        cond_flag,
   input logic        invalid_flag
);
   logic a_nan, b_nan, a_zero, b_zero;

   always_comb begin
      if (fmt_dbl) begin
         a_nan  = (op_a[62:52] == 11'h7FF) && (op_a[51:0] != '0);
         b_nan  = (op_b[62:52] == 11'h7FF) && (op_b[51:0] != '0);
         a_zero = op_a[62:0] == '0;
         b_zero = op_b[62:0] == '0;
      end else begin
         a_nan  = (op_a[30:23] == 8'hFF) && (op_a[22:0] != '0);
         b_nan  = (op_b[30:23] == 8'hFF) && (op_b[22:0] != '0);
         a_zero = op_a[30:0] == '0;
         b_zero = op_b[30:0] == '0;
      end
   end

   // R10
   cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_valid |=> $stable(cond_flag));

   // R10
   inv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_valid |=> !invalid_flag);

   // R3
   empty_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && pred[2:0] == 3'b000) |=> !cond_flag);

   // R4
   ordered_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !pred[0] && (a_nan || b_nan)) |=> !cond_flag);

   // R5
   unordered_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && pred[0] && (a_nan || b_nan)) |=> cond_flag);

   // R6
   zero_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && pred[1] && a_zero && b_zero) |=> cond_flag);
endmodule

bind fpcmp_unit fpcmp_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .fmt_dbl(fmt_dbl),
   .pred(pred), .op_a(op_a), .op_b(op_b),
   .cond_flag(cond_flag), .invalid_flag(invalid_flag)
);

// File: tb/sim_fpcmp_unit.sv
module sim_fpcmp_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp_valid = 1'b0;
   logic        fmt_dbl = 1'b0;
   logic [3:0]  pred = '0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic        cond_flag;
   logic        invalid_flag;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   localparam logic [3:0] P_F = 4'b0000, P_UN = 4'b0001, P_EQ = 4'b0010,
      P_LT = 4'b0100, P_LE = 4'b0110, P_ULE = 4'b0111, P_UEQ = 4'b0011,
      P_SLT = 4'b1100, P_SLE = 4'b1110;

   localparam logic [31:0] S_ONE = 32'h3F800000, S_TWO = 32'h40000000,
      S_MONE = 32'hBF800000, S_MTWO = 32'hC0000000, S_PINF = 32'h7F800000,
      S_NINF = 32'hFF800000, S_QNAN = 32'h7FC00000, S_SNAN = 32'h7F800001,
      S_PZ = 32'h00000000, S_NZ = 32'h80000000;
   localparam logic [63:0] D_ONE = 64'h3FF0000000000000,
      D_TWO = 64'h4000000000000000, D_MTHREE = 64'hC008000000000000,
      D_QNAN = 64'h7FF8000000000000, D_SNAN = 64'h7FF0000000000001,
      D_NZ = 64'h8000000000000000, D_PZ = 64'h0;

   fpcmp_unit u0 (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .fmt_dbl(fmt_dbl),
      .pred(pred), .op_a(op_a), .op_b(op_b),
      .cond_flag(cond_flag), .invalid_flag(invalid_flag)
   );

   always #10 clk = ~clk;

   task automatic check(string req, logic act_c, logic exp_c,
                        logic act_i, logic exp_i);
      checks++;
      if (act_c !== exp_c || act_i !== exp_i) begin
         errors++;
         $display("FAIL %s: cond=%b inv=%b expected cond=%b inv=%b",
                  req, act_c, act_i, exp_c, exp_i);
      end
   endtask

   // drive at negedge, capture at posedge, sample at next negedge
   task automatic cmp(string req, logic dbl, logic [3:0] p,
                      logic [63:0] a, logic [63:0] b,
                      logic exp_c, logic exp_i);
      @(negedge clk);
      fmt_dbl = dbl; pred = p; op_a = a; op_b = b; cmp_valid = 1'b1;
      @(negedge clk);
      cmp_valid = 1'b0;
      check(req, cond_flag, exp_c, invalid_flag, exp_i);
   endtask

   function automatic logic [63:0] s(logic [31:0] v);
      return {32'h0, v};
   endfunction

   task automatic t_reset();
      check("R1", cond_flag, 1'b0, invalid_flag, 1'b0);
   endtask

   task automatic t_single_rel();
      cmp("R3 lt true",  0, P_LT, s(S_ONE), s(S_TWO), 1, 0);
      cmp("R3 lt false", 0, P_LT, s(S_TWO), s(S_ONE), 0, 0);
      cmp("R3 eq",       0, P_EQ, s(S_TWO), s(S_TWO), 1, 0);
      cmp("R3 le eq",    0, P_LE, s(S_ONE), s(S_ONE), 1, 0);
      cmp("R3 false pr", 0, P_F,  s(S_ONE), s(S_ONE), 0, 0);
      cmp("R3 un only",  0, P_UN, s(S_ONE), s(S_TWO), 0, 0);
   endtask

   task automatic t_order();
      cmp("R7 neg<pos",     0, P_LT, s(S_MONE), s(S_ONE), 1, 0);
      cmp("R7 pos<neg",     0, P_LT, s(S_ONE), s(S_MONE), 0, 0);
      cmp("R7 -2<-1",       0, P_LT, s(S_MTWO), s(S_MONE), 1, 0);
      cmp("R7 -1<-2",       0, P_LT, s(S_MONE), s(S_MTWO), 0, 0);
      cmp("R7 -inf<-2",     0, P_LT, s(S_NINF), s(S_MTWO), 1, 0);
      cmp("R7 2<+inf",      0, P_LT, s(S_TWO), s(S_PINF), 1, 0);
      cmp("R7 inf==inf",    0, P_EQ, s(S_PINF), s(S_PINF), 1, 0);
   endtask

   task automatic t_zero();
      cmp("R6 +0==-0",  0, P_EQ, s(S_PZ), s(S_NZ), 1, 0);
      cmp("R6 -0<+0",   0, P_LT, s(S_NZ), s(S_PZ), 0, 0);
      cmp("R6 dbl -0==+0", 1, P_EQ, D_NZ, D_PZ, 1, 0);
   endtask

   task automatic t_upper_ignored();
      cmp("R2 upper lt", 0, P_LT, {32'hFFFFFFFF, S_ONE}, {32'h7FF80000, S_TWO}, 1, 0);
      cmp("R2 upper eq", 0, P_EQ, {32'h12345678, S_ONE}, {32'h9ABCDEF0, S_ONE}, 1, 0);
   endtask

   task automatic t_nan();
      cmp("R4 qnan le",   0, P_LE,  s(S_QNAN), s(S_ONE), 0, 0);
      cmp("R4 qnan eq",   0, P_EQ,  s(S_QNAN), s(S_QNAN), 0, 0);
      cmp("R5 qnan ule",  0, P_ULE, s(S_ONE), s(S_QNAN), 1, 0);
      cmp("R5 qnan un",   0, P_UN,  s(S_QNAN), s(S_TWO), 1, 0);
      cmp("R5 ueq ord",   0, P_UEQ, s(S_ONE), s(S_TWO), 0, 0);
   endtask

   task automatic t_invalid();
      cmp("R8 snan le",   0, P_LE,  s(S_SNAN), s(S_ONE), 0, 1);
      cmp("R8 snan un",   0, P_UN,  s(S_ONE), s(S_SNAN), 1, 1);
      cmp("R9 sig qnan",  0, P_SLT, s(S_QNAN), s(S_ONE), 0, 1);
      cmp("R9 quiet qnan", 0, P_LT, s(S_QNAN), s(S_ONE), 0, 0);
      cmp("R9 sig no nan", 0, P_SLE, s(S_ONE), s(S_TWO), 1, 0);
   endtask

   task automatic t_hold();
      cmp("R10 setup", 0, P_UN, s(S_SNAN), s(S_ONE), 1, 1);
      @(negedge clk);
      op_a = s(S_TWO); op_b = s(S_ONE); pred = P_LT;
      @(negedge clk);
      check("R10 idle 1", cond_flag, 1'b1, invalid_flag, 1'b0);
      op_a = s(S_SNAN); pred = P_F;
      @(negedge clk);
      check("R10 idle 2", cond_flag, 1'b1, invalid_flag, 1'b0);
   endtask

   task automatic t_double();
      cmp("R11 dbl lt",      1, P_LT,  D_ONE, D_TWO, 1, 0);
      cmp("R11 dbl neg",     1, P_LT,  D_MTHREE, D_ONE, 1, 0);
      cmp("R11 dbl gt",      1, P_LE,  D_TWO, D_ONE, 0, 0);
      cmp("R11 dbl qnan ord", 1, P_LE, D_QNAN, D_ONE, 0, 0);
      cmp("R11 dbl qnan un", 1, P_ULE, D_ONE, D_QNAN, 1, 0);
      cmp("R11 dbl snan",    1, P_EQ,  D_SNAN, D_ONE, 0, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_single_rel();
      t_order();
      t_zero();
      t_upper_ignored();
      t_nan();
      t_invalid();
      t_hold();
      t_double();
      done = 1;
   end

   initial begin
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule